// File: doc/BRIEF.md
# Round-Robin Shared-Bus Arbiter with Mastership Lock

This block decides which of up to eight processors drives a shared external bus. Each node raises a request line when it has a transfer pending. It raises a lock line when it needs to keep the bus across an atomic read-modify-write or a broadcast sequence. The arbiter keeps one current master. It presents that master as a one-hot grant vector and as a binary identifier. It also gives each node a registered "this node owns the bus" flag, which software polls while it waits for mastership.

Node 0 owns the bus when reset is released. The bus changes hands only when the current master has neither its request nor its lock raised. The search for the next owner then starts at the identifier just above the current master, moves upward and wraps past the highest node. A node counts as a candidate when it raises request or lock. When no node is a candidate, the current master keeps the bus. The arbiter stores no state apart from the identity of the current master. A node that raises its lock and drops it again before it wins therefore leaves no trace.

Top module: `bus_lock_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, master_id is 0, grant is 0x01 (bit i stands for node i) and own_flag is 0x01.
- R2: grant always has exactly one bit set, and that bit is the one at position master_id.
- R3: When the current master has both req and lock low and at least one other node has req or lock high, master_id at the next clock edge becomes the first such candidate found by counting upward from the current master.
- R4: The upward search wraps from node N-1 to node 0.
- R5: A master whose req is high keeps the bus at the next edge, whatever the other nodes request.
- R6: A master whose lock is high keeps the bus at the next edge, even with its req low and other nodes requesting.
- R7: Once the master clears lock and req while another node is a candidate, the bus passes at the next edge.
- R8: When no node has req or lock high, master_id does not change (the bus is parked on the current master).
- R9: A non-master node that raises its lock and then drops it before it wins has no effect on master_id or on later arbitration order.
- R10: own_flag equals the grant vector of the previous cycle.
- R11: master_id changes at most once per edge, and only to a node that was a candidate in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Per-node transfer request |
| lock | input | N | Per-node bus-lock request |
| grant | output | N | One-hot grant to the current master |
| master_id | output | IDW | Binary identifier of the current master |
| own_flag | output | N | Registered per-node "is bus master" indication |

## Verification
The hardest case to reach is a locked hold that overlaps a competing lock request which is then withdrawn. The stimulus parks the bus on one node with its lock high and its req low, so that a plain request-only hold cannot explain the result. It then raises and drops another node's lock while several other nodes request. Finally it releases the lock and checks that the next owner follows pure upward order with wrap-around, as if the withdrawn lock had never existed. After that, a long run of sparse random request and lock patterns drives the scoreboard through many handovers and parking cycles.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    // Reason the arbiter keeps or moves the bus in a given cycle.
    typedef enum logic [1:0] {
        HOLD_PARK  = 2'd0,
        HOLD_XFER  = 2'd1,
        HOLD_LOCK  = 2'd2,
        HAND_OVER  = 2'd3
    } hold_reason_e;

    // Outcome of the round-robin search.
    typedef struct packed {
        logic       found;
        logic [7:0] pick;
    } rr_result_t;

    function automatic int unsigned id_width(input int unsigned nodes);
        return (nodes > 1) ? $clog2(nodes) : 1;
    endfunction

endpackage

// File: rtl/bus_arb_rr_pick.sv
module bus_arb_rr_pick #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = 3
) (
    input  logic [N-1:0]   cand,
    input  logic [IDW-1:0] base,
    output logic           found,
    output logic [IDW-1:0] pick
);
    // Walk offsets from far to near so the nearest upward candidate wins.
    always_comb begin
        found = 1'b0;
        pick  = base;
        for (int k = int'(N) - 1; k >= 1; k--) begin
            int idx;
            idx = (int'(base) + k) % int'(N);
            if (cand[idx]) begin
                found = 1'b1;
                pick  = IDW'(idx);
            end
        end
    end
endmodule

// File: rtl/bus_arb_master_reg.sv
module bus_arb_master_reg #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           advance,
    input  logic [IDW-1:0] next_id,
    output logic [IDW-1:0] cur_id,
    output logic [N-1:0]   grant
);
    always_ff @(posedge clk) begin
        if (rst)          cur_id <= '0;
        else if (advance) cur_id <= next_id;
    end

    for (genvar g = 0; g < int'(N); g++) begin : g_dec
        assign grant[g] = (cur_id == IDW'(g));
    end
endmodule

// File: rtl/bus_arb_flag_reg.sv
module bus_arb_flag_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] grant,
    output logic [N-1:0] own_flag
);
    always_ff @(posedge clk) begin
        if (rst) own_flag <= N'(1);
        else     own_flag <= grant;
    end
endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter
    import bus_arb_pkg::*;
#(
    parameter int unsigned N = 8,
    localparam int unsigned IDW = id_width(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   req,
    input  logic [N-1:0]   lock,
    output logic [N-1:0]   grant,
    output logic [IDW-1:0] master_id,
    output logic [N-1:0]   own_flag
);
    logic [N-1:0]   cand;
    logic           found;
    logic [IDW-1:0] pick;
    hold_reason_e   reason;

    assign cand = req | lock;

    bus_arb_rr_pick #(.N(N), .IDW(IDW)) u_pick (
        .cand  (cand),
        .base  (master_id),
        .found (found),
        .pick  (pick)
    );

    // Lock outranks a pending transfer; either one pins the bus.
    always_comb begin
        if (lock[master_id])     reason = HOLD_LOCK;
        else if (req[master_id]) reason = HOLD_XFER;
        else if (found)          reason = HAND_OVER;
        else                     reason = HOLD_PARK;
    end

    bus_arb_master_reg #(.N(N), .IDW(IDW)) u_master (
        .clk     (clk),
        .rst     (rst),
        .advance (reason == HAND_OVER),
        .next_id (pick),
        .cur_id  (master_id),
        .grant   (grant)
    );

    bus_arb_flag_reg #(.N(N)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .grant    (grant),
        .own_flag (own_flag)
    );
endmodule

// File: rtl/bus_lock_arbiter_chk.sv
module bus_lock_arbiter_chk #(
    parameter int unsigned N   = 8,
    parameter int unsigned IDW = 3
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   req,
    input logic [N-1:0]   lock,
    input logic [N-1:0]   grant,
    input logic [IDW-1:0] master_id,
    input logic [N-1:0]   own_flag
);
    logic [N-1:0] cand_q;
    always_ff @(posedge clk) cand_q <= req | lock;

    // R2
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        ($countones(grant) == 1) && grant[master_id]);

    // R5
    p_xfer_hold_r5: assert property (@(posedge clk) disable iff (rst)
        req[master_id] |=> $stable(master_id));

    // R6
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
        lock[master_id] |=> $stable(master_id));

    // R7
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (!req[master_id] && !lock[master_id] && ((req | lock) != '0))
        |=> (master_id != $past(master_id)));

    // R8
    p_park_r8: assert property (@(posedge clk) disable iff (rst)
        ((req | lock) == '0) |=> $stable(master_id));

    // R10
    p_flag_delay_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (own_flag == $past(grant)));

    // R11
    p_target_r11: assert property (@(posedge clk) disable iff (rst)
        (master_id != $past(master_id)) |-> cand_q[master_id]);
endmodule

bind bus_lock_arbiter bus_lock_arbiter_chk #(.N(N), .IDW(IDW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .lock      (lock),
    .grant     (grant),
    .master_id (master_id),
    .own_flag  (own_flag)
);

// File: tb/bus_lock_arbiter_bench.sv
module bus_lock_arbiter_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] lock = '0;
    logic [N-1:0] grant;
    logic [2:0]   master_id;
    logic [N-1:0] own_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    bus_lock_arbiter #(.N(N)) u_bus_lock_arbiter (
        .clk(clk), .rst(rst), .req(req), .lock(lock),
        .grant(grant), .master_id(master_id), .own_flag(own_flag)
    );

    typedef struct {
        logic [2:0]   mid;
        logic [N-1:0] gnt;
        logic [N-1:0] flg;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    logic [2:0] m_cur = '0;

    function automatic logic [2:0] model_next(input logic [2:0] cur,
                                              input logic [N-1:0] r,
                                              input logic [N-1:0] l);
        logic [N-1:0] c;
        c = r | l;
        if (r[cur] || l[cur]) return cur;             // R5, R6
        for (int k = 1; k < N; k++) begin
            int idx;
            idx = (int'(cur) + k) % N;                // R3, R4
            if (c[idx]) return 3'(idx);
        end
        return cur;                                   // R8
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] l, input string tag);
        exp_t e;
        logic [2:0] nxt;
        @(negedge clk);
        req  = r;
        lock = l;
        nxt = model_next(m_cur, r, l);
        e.mid = nxt;
        e.gnt = N'(1) << nxt;
        e.flg = N'(1) << m_cur;
        e.tag = tag;
        exp_q.push_back(e);
        m_cur = nxt;
    endtask

    // Monitor: sample 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " master_id"}, 32'(master_id), 32'(e.mid));
                check({e.tag, " grant R2"}, 32'(grant), 32'(e.gnt));
                check({e.tag, " own_flag R10"}, 32'(own_flag), 32'(e.flg));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset master_id", 32'(master_id), 32'd0);
        check("R1 reset grant", 32'(grant), 32'h01);
        check("R1 reset own_flag", 32'(own_flag), 32'h01);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset master_id", 32'(master_id), 32'd0);
        check("R1 post-reset own_flag", 32'(own_flag), 32'h01);

        // R8: parking with nobody requesting
        step(8'h00, 8'h00, "R8 park");
        step(8'h00, 8'h00, "R8 park");
        // R3: hand to node 3
        step(8'h08, 8'h00, "R3 handover");
        // R5: master 3 keeps bus while requesting
        step(8'h28, 8'h00, "R5 hold xfer");
        step(8'h2A, 8'h00, "R5 hold xfer");
        // R3: upward from 3 picks 5 before 1
        step(8'h22, 8'h00, "R3 upward order");
        // R4: from 5 upward wraps to 1
        step(8'h02, 8'h00, "R4 wrap");
        // R6: master 1 locks, req low, others request
        step(8'h00, 8'h02, "R6 lock start");
        step(8'hF0, 8'h02, "R6 lock hold");
        // R9: node 6 raises then drops its lock while 1 holds the bus
        step(8'h90, 8'h42, "R9 lock raised");
        step(8'h90, 8'h02, "R9 lock dropped");
        step(8'h90, 8'h02, "R6 lock hold");
        // R7 + R9: release, next is 4 (upward from 1), not 6
        step(8'h90, 8'h00, "R7 release");
        step(8'h80, 8'h00, "R9 order kept");
        // R8: park on 7
        step(8'h00, 8'h00, "R8 park");
        // R4: wrap from 7 to 0
        step(8'h01, 8'h00, "R4 wrap to 0");
        // R11: lock-only candidate wins, then holds with lock
        step(8'h00, 8'h04, "R11 lock candidate");
        step(8'h08, 8'h04, "R6 lock hold");
        step(8'h00, 8'h00, "R8 park");

        // Random sparse patterns
        for (int i = 0; i < 500; i++) begin
            logic [N-1:0] r;
            logic [N-1:0] l;
            r = N'($urandom & $urandom);
            l = N'($urandom & $urandom & $urandom);
            step(r, l, "R3 random");
        end
        step(8'h00, 8'h00, "R8 park");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule